// File: doc/BRIEF.md
# Two-Stage Watchdog Escalation Controller

This block is a watchdog whose whole memory is two sticky status flags: an "armed" flag and a "pending" flag. A time-out is the rising edge of one chosen bit of a free-running time-base count that comes from outside the block. Each time-out moves the pair of flags forward. From the idle state, the first unserviced time-out arms the watchdog. The second sets the pending flag and, if enabled, raises an interrupt. The third, with both flags set, issues a reset request of the kind held in a two-bit control field.

Hardware only ever sets the flags, and only software ever clears them. Software clears them through a write-one-to-clear port. An interrupt handler typically clears the pending flag. A periodic service routine clears the armed flag. Either action moves the machine back toward idle, so a healthy system never reaches the reset stage. A hung system, which issues no clears, always ends in a reset request.

Top module: `wdog_escalator`

## Requirements
- R1: In the cycle after a synchronous reset, both flags read 0 (`status_o` = 2'b00), `irq_o` is 0, `rst_req_o` is 2'b00 and `last_rst_o` is 2'b00.
- R2: A time-out is the 0-to-1 change of time-base bit `TAP_LO + period_sel*TAP_STEP`; with defaults, `period_sel` 0..3 selects bits 4, 7, 10 and 13. A bit held high gives one time-out only. Edges on bits that are not selected have no effect. The flags show the result in the cycle after the edge is seen.
- R3: A time-out while armed is 0 sets armed to 1 and leaves pending unchanged. This holds also from the state armed=0, pending=1. `status_o` is {armed, pending}, so bit 1 is armed and bit 0 is pending.
- R4: A time-out while armed=1 and pending=0 sets pending to 1, whether or not `irq_en` is set. `irq_o` is a level that equals pending AND `irq_en`.
- R5: A time-out while both flags are 1 drives `rst_req_o` with the value of `rst_ctl` for exactly one cycle, starting in the cycle after the edge. Codes 01, 10 and 11 stand for core, chip and system reset. Code 00 produces no request, and the flags stay set. With no software clears, three time-outs from idle produce a request.
- R6: One cycle after a nonzero request, `last_rst_o` takes its code and holds it until the next request.
- R7: A cycle with `clr_we`=1 clears each flag whose bit in `clr_data` is 1 (bit 1 = armed, bit 0 = pending). Zero bits leave their flag unchanged.
- R8: When a software clear and a hardware set hit the same flag in the same cycle, the flag ends up set. The decision uses the flag values from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase_i | input | TB_W | Free-running time-base count |
| period_sel | input | SEL_W | Chooses which time-base bit produces time-outs |
| irq_en | input | 1 | Interrupt enable |
| rst_ctl | input | 2 | Kind of reset to request on the third time-out (00 none) |
| clr_we | input | 1 | Write strobe for the write-one-to-clear port |
| clr_data | input | 2 | Clear mask: bit 1 armed, bit 0 pending |
| status_o | output | 2 | Flag readback {armed, pending} |
| irq_o | output | 1 | Watchdog interrupt level |
| rst_req_o | output | 2 | One-cycle reset request carrying the kind code |
| last_rst_o | output | 2 | Kind code of the most recent request |

## Verification
The assertions take some things for granted about the inputs. The time-base bit in use must go low between two time-outs, so no two time-outs fall in back-to-back cycles. The assertions also assume that `period_sel` does not change while the selected bit is high, since a switch to a tap that is already high would look like an edge. The stimulus drives the time base directly rather than from a counter: it raises exactly one tapped bit, holds it for one or more cycles and drops it before the next event, and it changes `period_sel` only while every bit is low. All inputs change on the falling clock edge, and clears are timed either between events or on the exact cycle of an edge when a collision is under test.

// File: rtl/wdog_esc_pkg.sv
package wdog_esc_pkg;

    // Bit positions inside the status readback and the clear mask
    localparam int FLAG_W   = 2;
    localparam int BIT_PEND = 0;
    localparam int BIT_ARM  = 1;

    typedef enum logic [1:0] {
        RK_NONE = 2'b00,
        RK_CORE = 2'b01,
        RK_CHIP = 2'b10,
        RK_SYS  = 2'b11
    } rst_kind_e;

    typedef struct packed {
        logic armed;
        logic pend;
    } wd_flags_t;

    // Position of the time-base bit watched for a given period select
    function automatic int tap_pos(input int sel, input int lo, input int step);
        return lo + sel * step;
    endfunction

    function automatic logic [FLAG_W-1:0] flags_to_bits(input wd_flags_t f);
        logic [FLAG_W-1:0] b;
        b = '0;
        b[BIT_ARM]  = f.armed;
        b[BIT_PEND] = f.pend;
        return b;
    endfunction

endpackage

// File: rtl/wdog_tap_edge.sv
module wdog_tap_edge #(
    parameter int TB_W     = 16,
    parameter int SEL_W    = 2,
    parameter int TAP_LO   = 4,
    parameter int TAP_STEP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TB_W-1:0]  tbase_i,
    input  logic [SEL_W-1:0] period_sel,
    output logic             timeout_o
);
    import wdog_esc_pkg::*;

    localparam int NTAPS = 2 ** SEL_W;

    logic [NTAPS-1:0] taps;
    logic             cur_bit;
    logic             prev_bit;
    logic             unused_tb;

    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        localparam int POS = tap_pos(g, TAP_LO, TAP_STEP);
        assign taps[g] = tbase_i[POS];
    end

    assign unused_tb = ^tbase_i;
    assign cur_bit   = taps[period_sel];

    // During reset the history follows the input, so a bit that is already
    // high when reset lifts is not taken as an edge.
    always_ff @(posedge clk) begin
        prev_bit <= cur_bit;
    end

    assign timeout_o = cur_bit & ~prev_bit & ~rst;

endmodule

// File: rtl/wdog_flag_fsm.sv
module wdog_flag_fsm
    import wdog_esc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              timeout_i,
    input  logic              clr_we,
    input  logic [FLAG_W-1:0] clr_data,
    output wd_flags_t         flags_o,
    output logic              fire_o
);
    wd_flags_t flags_q;
    wd_flags_t flags_d;
    logic      set_arm;
    logic      set_pend;
    logic      clr_arm;
    logic      clr_pend;

    // Hardware sets, decided on the flag values from before this cycle
    assign set_arm  = timeout_i & ~flags_q.armed;
    assign set_pend = timeout_i &  flags_q.armed & ~flags_q.pend;
    assign fire_o   = timeout_i &  flags_q.armed &  flags_q.pend;

    assign clr_arm  = clr_we & clr_data[BIT_ARM];
    assign clr_pend = clr_we & clr_data[BIT_PEND];

    always_comb begin
        flags_d = flags_q;
        if (clr_arm)  flags_d.armed = 1'b0;
        if (clr_pend) flags_d.pend  = 1'b0;
        if (set_arm)  flags_d.armed = 1'b1;
        if (set_pend) flags_d.pend  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/wdog_rst_req.sv
module wdog_rst_req
    import wdog_esc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire_i,
    input  rst_kind_e kind_i,
    output rst_kind_e req_o,
    output rst_kind_e last_o
);
    rst_kind_e req_q;
    rst_kind_e last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= RK_NONE;
            last_q <= RK_NONE;
        end else begin
            req_q <= fire_i ? kind_i : RK_NONE;
            if (req_q != RK_NONE) last_q <= req_q;
        end
    end

    assign req_o  = req_q;
    assign last_o = last_q;

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
    import wdog_esc_pkg::*;
#(
    parameter int TB_W     = 16,
    parameter int SEL_W    = 2,
    parameter int TAP_LO   = 4,
    parameter int TAP_STEP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TB_W-1:0]   tbase_i,
    input  logic [SEL_W-1:0]  period_sel,
    input  logic              irq_en,
    input  logic [1:0]        rst_ctl,
    input  logic              clr_we,
    input  logic [FLAG_W-1:0] clr_data,
    output logic [FLAG_W-1:0] status_o,
    output logic              irq_o,
    output logic [1:0]        rst_req_o,
    output logic [1:0]        last_rst_o
);
    logic      to_evt;
    logic      fire;
    wd_flags_t flags;
    rst_kind_e req_k;
    rst_kind_e last_k;
    logic      armed_q;
    logic      pend_q;

    wdog_tap_edge #(
        .TB_W    (TB_W),
        .SEL_W   (SEL_W),
        .TAP_LO  (TAP_LO),
        .TAP_STEP(TAP_STEP)
    ) u_tap (
        .clk       (clk),
        .rst       (rst),
        .tbase_i   (tbase_i),
        .period_sel(period_sel),
        .timeout_o (to_evt)
    );

    wdog_flag_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .timeout_i(to_evt),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .flags_o  (flags),
        .fire_o   (fire)
    );

    wdog_rst_req u_req (
        .clk   (clk),
        .rst   (rst),
        .fire_i(fire),
        .kind_i(rst_kind_e'(rst_ctl)),
        .req_o (req_k),
        .last_o(last_k)
    );

    assign armed_q    = flags.armed;
    assign pend_q     = flags.pend;
    assign status_o   = flags_to_bits(flags);
    assign irq_o      = flags.pend & irq_en;
    assign rst_req_o  = req_k;
    assign last_rst_o = last_k;

endmodule

// File: rtl/wdog_escalator_chk.sv
module wdog_escalator_chk (
    input logic       clk,
    input logic       rst,
    input logic       to_evt,
    input logic       armed_q,
    input logic       pend_q,
    input logic       clr_we,
    input logic [1:0] clr_data,
    input logic [1:0] rst_ctl,
    input logic [1:0] rst_req_o,
    input logic [1:0] last_rst_o
);
    AST_ARM_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        to_evt && !armed_q |=> armed_q); // R3

    AST_PEND_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(armed_q) && $past(to_evt)); // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        pend_q && !(clr_we && clr_data[0]) |=> pend_q); // R7

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        armed_q && !(clr_we && clr_data[1]) |=> armed_q); // R7

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        to_evt && !armed_q && clr_we && clr_data[1] |=> armed_q); // R8

    AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        rst_req_o != 2'b00 |-> $past(to_evt && armed_q && pend_q)
                              && rst_req_o == $past(rst_ctl)); // R5

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rst_req_o != 2'b00 |=> rst_req_o == 2'b00); // R5

    AST_LAST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rst_req_o != 2'b00 |=> last_rst_o == $past(rst_req_o)); // R6

endmodule

bind wdog_escalator wdog_escalator_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .to_evt    (to_evt),
    .armed_q   (armed_q),
    .pend_q    (pend_q),
    .clr_we    (clr_we),
    .clr_data  (clr_data),
    .rst_ctl   (rst_ctl),
    .rst_req_o (rst_req_o),
    .last_rst_o(last_rst_o)
);

// File: tb/wdog_escalator_tb.sv
`timescale 1ns/1ps
module wdog_escalator_tb;

    localparam int TB_W     = 16;
    localparam int TAP_LO   = 4;
    localparam int TAP_STEP = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic [TB_W-1:0]  tbase_i;
    logic [1:0]       period_sel;
    logic             irq_en;
    logic [1:0]       rst_ctl;
    logic             clr_we;
    logic [1:0]       clr_data;
    logic [1:0]       status_o;
    logic             irq_o;
    logic [1:0]       rst_req_o;
    logic [1:0]       last_rst_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wdog_escalator #(
        .TB_W(TB_W), .SEL_W(2), .TAP_LO(TAP_LO), .TAP_STEP(TAP_STEP)
    ) u_dut (
        .clk(clk), .rst(rst), .tbase_i(tbase_i), .period_sel(period_sel),
        .irq_en(irq_en), .rst_ctl(rst_ctl), .clr_we(clr_we), .clr_data(clr_data),
        .status_o(status_o), .irq_o(irq_o), .rst_req_o(rst_req_o),
        .last_rst_o(last_rst_o)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int tap_of(input int sel);
        return TAP_LO + sel * TAP_STEP;
    endfunction

    // Raise the selected tap for one cycle, then drop it.
    task automatic tick();
        tbase_i = '0;
        tbase_i[tap_of(int'(period_sel))] = 1'b1;
        @(negedge clk);
        tbase_i = '0;
        @(negedge clk);
    endtask

    task automatic wclr(input logic [1:0] m);
        clr_we = 1'b1; clr_data = m;
        @(negedge clk);
        clr_we = 1'b0; clr_data = 2'b00;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 status", {2'b0, status_o}, 4'h0);
        check("R1 irq", {3'b0, irq_o}, 4'h0);
        check("R1 req", {2'b0, rst_req_o}, 4'h0);
        check("R1 last", {2'b0, last_rst_o}, 4'h0);
    endtask

    task automatic t_tap();
        do_reset();
        period_sel = 2'd2;
        tbase_i = '0; tbase_i[tap_of(0)] = 1'b1; tbase_i[tap_of(3)] = 1'b1;
        @(negedge clk);
        tbase_i = '0;
        @(negedge clk);
        check("R2 other taps ignored", {2'b0, status_o}, 4'h0);
        tbase_i = '0; tbase_i[tap_of(2)] = 1'b1;
        @(negedge clk);
        check("R2 selected edge", {2'b0, status_o}, 4'h2);
        @(negedge clk); @(negedge clk);
        check("R2 held level one event", {2'b0, status_o}, 4'h2);
        tbase_i = '0;
        @(negedge clk);
        period_sel = 2'd0;
        tick();
        check("R2 new select", {2'b0, status_o}, 4'h3);
    endtask

    task automatic t_arm();
        do_reset();
        irq_en = 1'b1;
        tick();
        check("R3 armed only", {2'b0, status_o}, 4'h2);
        check("R3 no irq", {3'b0, irq_o}, 4'h0);
        tick();
        wclr(2'b10);
        check("R3 pend-only state", {2'b0, status_o}, 4'h1);
        tick();
        check("R3 arm from pend-only", {2'b0, status_o}, 4'h3);
        check("R3 no new request", {2'b0, rst_req_o}, 4'h0);
    endtask

    task automatic t_pend();
        do_reset();
        irq_en = 1'b0;
        tick(); tick();
        check("R4 pend set with irq off", {2'b0, status_o}, 4'h3);
        check("R4 irq masked", {3'b0, irq_o}, 4'h0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R4 irq level", {3'b0, irq_o}, 4'h1);
    endtask

    task automatic t_clear();
        wclr(2'b00);
        check("R7 zero mask", {2'b0, status_o}, 4'h3);
        wclr(2'b01);
        check("R7 clear pend", {2'b0, status_o}, 4'h2);
        check("R7 irq drops", {3'b0, irq_o}, 4'h0);
        wclr(2'b10);
        check("R7 clear arm", {2'b0, status_o}, 4'h0);
    endtask

    task automatic t_collide();
        do_reset();
        tbase_i = '0; tbase_i[tap_of(int'(period_sel))] = 1'b1;
        clr_we = 1'b1; clr_data = 2'b11;
        @(negedge clk);
        tbase_i = '0; clr_we = 1'b0; clr_data = 2'b00;
        @(negedge clk);
        check("R8 arm set beats clear", {2'b0, status_o}, 4'h2);
        tbase_i = '0; tbase_i[tap_of(int'(period_sel))] = 1'b1;
        clr_we = 1'b1; clr_data = 2'b01;
        @(negedge clk);
        tbase_i = '0; clr_we = 1'b0; clr_data = 2'b00;
        @(negedge clk);
        check("R8 pend set beats clear", {2'b0, status_o}, 4'h3);
    endtask

    task automatic t_escalate();
        do_reset();
        rst_ctl = 2'b10;
        tick(); tick();
        tbase_i = '0; tbase_i[tap_of(int'(period_sel))] = 1'b1;
        @(negedge clk);
        check("R5 request code", {2'b0, rst_req_o}, 4'h2);
        tbase_i = '0;
        @(negedge clk);
        check("R5 one cycle", {2'b0, rst_req_o}, 4'h0);
        check("R6 last latched", {2'b0, last_rst_o}, 4'h2);
        check("R5 flags held", {2'b0, status_o}, 4'h3);
        rst_ctl = 2'b00;
        tbase_i = '0; tbase_i[tap_of(int'(period_sel))] = 1'b1;
        @(negedge clk);
        check("R5 no-reset code", {2'b0, rst_req_o}, 4'h0);
        tbase_i = '0;
        @(negedge clk);
        check("R6 last kept", {2'b0, last_rst_o}, 4'h2);
        rst_ctl = 2'b11;
        tick();
        check("R6 last updated", {2'b0, last_rst_o}, 4'h3);
    endtask

    initial begin
        rst = 1'b1; tbase_i = '0; period_sel = 2'd1; irq_en = 1'b0;
        rst_ctl = 2'b01; clr_we = 1'b0; clr_data = 2'b00;
        @(negedge clk);
        t_reset();
        t_tap();
        t_arm();
        t_pend();
        t_clear();
        t_collide();
        t_escalate();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule